// File: doc/BRIEF.md
# Decision-Aided Symbol Timing Tracking Loop

This block is the fine stage of a symbol timing recovery chain. Once per symbol it takes one interpolated matched-filter sample together with the hard decision that an external iterative decoder made for that same symbol. From the current and previous sample/decision pairs it forms a timing error of the Mueller-Muller kind. It then integrates that error into a fractional timing correction, which a downstream interpolator applies. The loop follows slow random-walk jitter and removes whatever delay and clock-rate error the coarse acquisition stage left behind.

The decisions are single bits (1 stands for +1 and 0 for -1), so both products in the detector are done by conditional negation. The loop gain is a programmable power of two, applied as an arithmetic right shift. The accumulated correction is clamped to plus or minus half a symbol. A small sequencer has two states. ST_EMPTY means no previous pair is held, and it is the state after reset. ST_TRACK means a previous pair is held. The transition "prime" (ST_EMPTY to ST_TRACK) is taken on the first valid symbol, which only loads the history. The transition "update" (ST_TRACK to ST_TRACK) is taken on every later valid symbol. It loads the history and steps the correction. When no symbol is valid, either state holds.

Top module: `mm_timing_loop`

## Requirements
- R1: While reset is asserted, corr_out is 0 and corr_valid is 0. The held previous sample and decision are cleared.
- R2: corr_valid equals in_valid delayed by exactly one clock. corr_out is a register whose new value is visible in the same cycle that corr_valid is high.
- R3: The first symbol with in_valid high after reset only loads the history. The corr_out that follows it is unchanged, which is 0.
- R4: For each later valid symbol, with s the signed sample and d = +1 when dec_in is 1 and -1 when dec_in is 0, the error is u = s_prev*d - s*d_prev. The new correction is c + (u >>> kp_shift), clamped as stated in R6 and R7.
- R5: The gain shift is an arithmetic right shift, so it rounds toward minus infinity. With the history (2000,+1), the symbol (2003,+1) and kp_shift = 1, a correction of 0 becomes -2.
- R6: corr_out never exceeds +2^(CW-2), which is +16384 at the defaults and stands for +0.5 symbol. A sum above this value is clamped to exactly that value.
- R7: corr_out never goes below -2^(CW-2), which is -16384 at the defaults and stands for -0.5 symbol. A sum below this value is clamped to exactly that value.
- R8: A cycle with in_valid low changes neither corr_out nor the held previous sample and decision.
- R9: corr_out is two's complement with one LSB equal to 2^-(CW-1) of a symbol period. Within one clock it moves by no more than 2^SW LSBs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | samp_in and dec_in carry a symbol this cycle |
| samp_in | input | SW | Interpolated symbol sample, signed |
| dec_in | input | 1 | Decoded symbol: 1 means +1, 0 means -1 |
| kp_shift | input | SHW | Loop gain as a right-shift amount |
| corr_out | output | CW | Fractional timing correction, signed |
| corr_valid | output | 1 | corr_out was updated for a symbol |

## Verification
The bench targets the first symbol after each reset. A loop that ran the detector against cleared history would step away from 0 there. It checks an odd negative error under a one-bit shift, where a design that truncates toward zero gives -1 instead of -2. Idle cycles are filled with junk samples followed by a symbol that repeats the last one. A design that loads history or accumulates without in_valid would then move off its held value. Two steady error patterns drive the correction hard into each rail, where a wrapping or off-by-one clamp misses the exact limit. Long random runs with mixed gains compare every symbol against a reference model.

// File: rtl/mm_pkg.sv
package mm_pkg;

    // Sequencer states: no history held yet, or tracking with history
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_TRACK = 1'b1
    } mm_state_e;

endpackage

// File: rtl/mm_seq.sv
module mm_seq
    import mm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic hist_ld,
    output logic upd_en,
    output logic out_vld
);

    mm_state_e state_q;
    mm_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: prime (EMPTY->TRACK), update (TRACK->TRACK)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Per-state outputs
    always_comb begin
        hist_ld = 1'b0;
        upd_en  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                hist_ld = in_valid;
                upd_en  = 1'b0;
            end
            ST_TRACK: begin
                hist_ld = in_valid;
                upd_en  = in_valid;
            end
            default: begin
                hist_ld = 1'b0;
                upd_en  = 1'b0;
            end
        endcase
    end

    // Output strobe lags the input strobe by one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_valid;
        end
    end

endmodule

// File: rtl/mm_ted.sv
module mm_ted #(
    parameter int SW = 12,
    localparam int EW = SW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hist_ld,
    input  logic signed [SW-1:0] samp_in,
    input  logic                 dec_in,
    output logic signed [EW-1:0] err
);

    logic signed [SW-1:0] prev_s;
    logic                 prev_d;

    // History of the last accepted sample/decision pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_s <= '0;
            prev_d <= 1'b0;
        end else if (hist_ld) begin
            prev_s <= samp_in;
            prev_d <= dec_in;
        end
    end

    logic signed [SW:0] prev_ext;
    logic signed [SW:0] cur_ext;
    logic signed [SW:0] term_a;
    logic signed [SW:0] term_b;

    // Products with +/-1 decisions done as conditional negation
    always_comb begin
        prev_ext = {prev_s[SW-1], prev_s};
        cur_ext  = {samp_in[SW-1], samp_in};
        term_a   = dec_in ? prev_ext : -prev_ext;
        term_b   = prev_d ? cur_ext  : -cur_ext;
        err      = {term_a[SW], term_a} - {term_b[SW], term_b};
    end

endmodule

// File: rtl/mm_loop_acc.sv
module mm_loop_acc #(
    parameter int EW  = 14,
    parameter int CW  = 16,
    parameter int SHW = 4,
    localparam int HALF = 1 << (CW - 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_en,
    input  logic signed [EW-1:0]  err,
    input  logic [SHW-1:0]        kp_shift,
    output logic signed [CW-1:0]  corr
);

    logic signed [EW-1:0] step;
    logic signed [CW:0]   sum;
    logic signed [CW-1:0] nxt;

    always_comb begin
        step = err >>> kp_shift;
        sum  = {corr[CW-1], corr} + {{(CW + 1 - EW){step[EW-1]}}, step};
        if (sum > HALF) begin
            nxt = CW'(HALF);
        end else if (sum < -HALF) begin
            nxt = CW'(-HALF);
        end else begin
            nxt = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr <= '0;
        end else if (upd_en) begin
            corr <= nxt;
        end
    end

endmodule

// File: rtl/mm_timing_loop.sv
module mm_timing_loop #(
    parameter int SW  = 12,
    parameter int CW  = 16,
    parameter int SHW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] samp_in,
    input  logic                 dec_in,
    input  logic [SHW-1:0]       kp_shift,
    output logic signed [CW-1:0] corr_out,
    output logic                 corr_valid
);

    localparam int EW = SW + 2;

    logic                 hist_ld;
    logic                 upd_en;
    logic signed [EW-1:0] err;

    mm_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .hist_ld  (hist_ld),
        .upd_en   (upd_en),
        .out_vld  (corr_valid)
    );

    mm_ted #(.SW(SW)) u_ted (
        .clk     (clk),
        .rst_n   (rst_n),
        .hist_ld (hist_ld),
        .samp_in (samp_in),
        .dec_in  (dec_in),
        .err     (err)
    );

    mm_loop_acc #(.EW(EW), .CW(CW), .SHW(SHW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .err      (err),
        .kp_shift (kp_shift),
        .corr     (corr_out)
    );

endmodule

// File: rtl/mm_timing_loop_chk.sv
module mm_timing_loop_chk #(
    parameter int SW = 12,
    parameter int CW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [CW-1:0] corr_out,
    input logic                 corr_valid
);

    localparam int HALF = 1 << (CW - 2);
    localparam int MAXD = 1 << SW;

    logic                 past_ok;
    logic                 primed;
    logic signed [CW-1:0] last_out;
    int                   delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            primed   <= 1'b0;
            last_out <= '0;
        end else begin
            past_ok  <= 1'b1;
            last_out <= corr_out;
            if (in_valid) primed <= 1'b1;
        end
    end

    always_comb delta = int'(corr_out) - int'(last_out);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (corr_out == '0 && !corr_valid));

    // R2
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (corr_valid == $past(in_valid)));

    // R3
    first_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && !$past(primed)) |-> (corr_out == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |-> $stable(corr_out));

    // R9
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (delta <= MAXD && delta >= -MAXD));

    // R6
    upper_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(corr_out) <= HALF);

    // R7
    lower_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(corr_out) >= -HALF);

endmodule

bind mm_timing_loop mm_timing_loop_chk #(.SW(SW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .corr_out   (corr_out),
    .corr_valid (corr_valid)
);

// File: tb/sim_mm_timing_loop.sv
module sim_mm_timing_loop;

    localparam int CLK_P = 10;
    localparam int SW    = 12;
    localparam int CW    = 16;
    localparam int SHW   = 4;
    localparam int HALF  = 1 << (CW - 2);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] samp_in = '0;
    logic                 dec_in = 1'b0;
    logic [SHW-1:0]       kp_shift = '0;
    logic signed [CW-1:0] corr_out;
    logic                 corr_valid;

    int total = 0;
    int bad   = 0;
    int mc, mps, mpd;
    bit mprimed;

    always #(CLK_P/2) clk = ~clk;

    mm_timing_loop #(.SW(SW), .CW(CW), .SHW(SHW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .samp_in(samp_in),
        .dec_in(dec_in), .kp_shift(kp_shift), .corr_out(corr_out),
        .corr_valid(corr_valid)
    );

    function automatic int clampc(int v);
        if (v > HALF)  return HALF;
        if (v < -HALF) return -HALF;
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mc = 0; mps = 0; mpd = -1; mprimed = 0;
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic apply(bit v, int s, bit d, int k, string req);
        int dv, u;
        in_valid = v;
        samp_in  = SW'(s);
        dec_in   = d;
        kp_shift = SHW'(k);
        @(negedge clk);
        dv = d ? 1 : -1;
        if (v) begin
            if (mprimed) begin
                u  = mps * dv - s * mpd;
                mc = clampc(mc + (u >>> k));
            end
            mps = s; mpd = dv; mprimed = 1;
        end
        check(corr_valid == v, "R2", int'(corr_valid), int'(v));
        check(int'(corr_out) == mc, req, int'(corr_out), mc);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b1; samp_in = SW'(777); dec_in = 1'b1;
        repeat (3) @(negedge clk);
        model_reset();
        check(corr_out == '0, "R1", int'(corr_out), 0);
        check(corr_valid == 1'b0, "R1", int'(corr_valid), 0);
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();

        // R3: first symbol after reset leaves correction at 0
        apply(1, 2000, 1, 0, "R3");
        check(corr_out == '0, "R3", int'(corr_out), 0);

        // R5: u = -3, shift 1 -> floor gives -2
        apply(1, 2003, 1, 1, "R5");
        check(int'(corr_out) == -2, "R5", int'(corr_out), -2);

        // R8: junk during idle must not touch output or history
        for (int i = 0; i < 4; i++) apply(0, -1500 + i, 0, 0, "R8");
        apply(1, 2003, 1, 0, "R8");
        check(int'(corr_out) == -2, "R8", int'(corr_out), -2);

        // R6: steady +2A error pattern pushes to the upper rail
        for (int i = 0; i < 24; i++) begin
            case (i % 4)
                0: apply(1, -2000, 1, 0, "R6");
                1: apply(1, -2000, 0, 0, "R6");
                2: apply(1,  2000, 0, 0, "R6");
                default: apply(1, 2000, 1, 0, "R6");
            endcase
        end
        check(int'(corr_out) == HALF, "R6", int'(corr_out), HALF);

        // R7: steady -2A error pattern pushes to the lower rail
        for (int i = 0; i < 40; i++) begin
            case (i % 4)
                0: apply(1,  2000, 1, 0, "R7");
                1: apply(1,  2000, 0, 0, "R7");
                2: apply(1, -2000, 0, 0, "R7");
                default: apply(1, -2000, 1, 0, "R7");
            endcase
        end
        check(int'(corr_out) == -HALF, "R7", int'(corr_out), -HALF);

        // R1/R3 again after a mid-run reset
        do_reset();
        apply(1, -1234, 0, 2, "R3");
        check(corr_out == '0, "R3", int'(corr_out), 0);

        // R4/R9: random symbols, gaps and gains
        for (int i = 0; i < 5000; i++) begin
            int s, k;
            bit v, d;
            v = ($urandom % 4) != 0;
            s = int'($urandom % 4096) - 2048;
            d = $urandom % 2;
            k = $urandom % 8;
            apply(v, s, d, k, "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule